// File: doc/BRIEF.md
# LCD AC-Bias Toggle Generator

This block produces the alternating bias level that a liquid-crystal panel uses to reverse its drive polarity at regular intervals, so that no net DC charge accumulates in the glass. It counts line-clock strobes. After a programmable number of them it flips the bias output and restarts its count.

A second counter tallies the bias flips. Once a programmable number of flips has been reached, it raises a sticky status flag that serves as an interrupt request. While the flag stands, flips are not counted. When software pulses the clear input, the flag drops and the tally starts again from zero. Programming a flip count of zero turns the status function off.

The two count values are sampled live every cycle. Output polarity control and register access belong to the surrounding display controller.

Top module: `acb_toggle_gen`

## Requirements
- R1: After reset, `bias_o` is 0 and `status_o` is 0, and both internal counters start from zero.
- R2: With `period_i` = P (1 to 255), `bias_o` inverts on every P-th strobe of `line_stb_i`. The change appears at the same clock edge that samples that strobe.
- R3: A `period_i` of 0 behaves like 1, so every line strobe inverts `bias_o`.
- R4: With `xcount_i` = C (1 to 15), `status_o` rises at the clock edge of the C-th bias inversion counted since reset or since the last clear.
- R5: `status_o` stays at 1 until a clear. Bias inversions that occur while it is 1 are not counted.
- R6: A pulse on `status_clr_i` with `status_o` at 1 and no simultaneous flag-setting inversion drops `status_o` at the next edge. Counting then restarts from zero, so C further inversions are needed.
- R7: If a clear pulse coincides with the inversion that completes the count, `status_o` becomes 1.
- R8: With `xcount_i` = 0, `status_o` never rises and the inversion tally is held at zero.
- R9: In a cycle without a line strobe, `bias_o` keeps its value. This holds whatever `status_clr_i` or the count inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_stb_i | input | 1 | Single-cycle line-clock strobe |
| period_i | input | 8 | Line strobes per bias inversion (0 acts as 1) |
| xcount_i | input | 4 | Bias inversions per status event (0 disables) |
| status_clr_i | input | 1 | Software clear pulse for the status flag |
| bias_o | output | 1 | Raw AC-bias level |
| status_o | output | 1 | Sticky status / interrupt request |

## Verification
The bench targets a period of zero. A design that decodes zero literally would stall the bias forever or wait 256 strobes between flips.

It lets inversions occur while the flag is up. A counter that is not frozen would raise the next flag too early after the clear.

It fires a clear in the same cycle as the completing inversion. Giving the clear priority would lose that interrupt.

It sets the flip count to zero. Any flag at all then shows the disable is broken.

Random strobe spacing, periods and counts, together with random clears, exercise counter reloads, including values that change in mid-count.

// File: rtl/acb_pkg.sv
package acb_pkg;

   // Effective divide limit: a programmed zero acts as one.
   function automatic int unsigned eff_limit(input int unsigned prog);
      return (prog == 0) ? 1 : prog;
   endfunction

   typedef struct packed {
      logic toggle;
      logic level;
   } bias_evt_t;

endpackage

// File: rtl/acb_line_div.sv
module acb_line_div
   import acb_pkg::*;
#(
   parameter int unsigned PERIOD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_stb,
   input  logic [PERIOD_W-1:0] period,
   output bias_evt_t           evt
);
   localparam int unsigned CW = PERIOD_W + 1;

   logic [PERIOD_W-1:0] cnt_q;
   logic [CW-1:0]       limit;
   logic [CW-1:0]       cnt_next_ext;
   logic                terminal;
   logic                level_q;

   always_comb begin
      limit        = (period == '0) ? CW'(1) : {1'b0, period};
      cnt_next_ext = {1'b0, cnt_q} + CW'(1);
      terminal     = (cnt_next_ext >= limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         level_q <= 1'b0;
      end else if (line_stb) begin
         if (terminal) begin
            cnt_q   <= '0;
            level_q <= ~level_q;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   assign evt.toggle = line_stb & terminal;
   assign evt.level  = level_q;

endmodule

// File: rtl/acb_xition_cnt.sv
module acb_xition_cnt #(
   parameter int unsigned XCNT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              toggle_evt,
   input  logic [XCNT_W-1:0] xcount,
   input  logic              status_clr,
   output logic              flag
);
   localparam int unsigned EW = XCNT_W + 1;

   logic [XCNT_W-1:0] tcnt_q;
   logic              flag_q;
   logic              enabled;
   logic              reach;
   logic              set_evt;

   always_comb begin
      enabled = |xcount;
      reach   = (({1'b0, tcnt_q} + EW'(1)) >= {1'b0, xcount});
      set_evt = toggle_evt & enabled & ~flag_q & reach;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt_q <= '0;
      end else if (!enabled) begin
         tcnt_q <= '0;
      end else if (toggle_evt && !flag_q) begin
         tcnt_q <= set_evt ? '0 : tcnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (set_evt)    flag_q <= 1'b1;
      else if (status_clr) flag_q <= 1'b0;
   end

   assign flag = flag_q;

endmodule

// File: rtl/acb_toggle_gen.sv
module acb_toggle_gen
   import acb_pkg::*;
#(
   parameter int unsigned PERIOD_W = 8,
   parameter int unsigned XCNT_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_stb_i,
   input  logic [PERIOD_W-1:0] period_i,
   input  logic [XCNT_W-1:0]   xcount_i,
   input  logic                status_clr_i,
   output logic                bias_o,
   output logic                status_o
);
   generate
      if (PERIOD_W < 1 || PERIOD_W > 16) begin : g_bad_period
         $error("acb_toggle_gen: PERIOD_W out of range");
      end
      if (XCNT_W < 1 || XCNT_W > 16) begin : g_bad_xcnt
         $error("acb_toggle_gen: XCNT_W out of range");
      end
   endgenerate

   bias_evt_t evt;

   acb_line_div #(.PERIOD_W(PERIOD_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_stb (line_stb_i),
      .period   (period_i),
      .evt      (evt)
   );

   acb_xition_cnt #(.XCNT_W(XCNT_W)) u_xcnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .toggle_evt (evt.toggle),
      .xcount     (xcount_i),
      .status_clr (status_clr_i),
      .flag       (status_o)
   );

   assign bias_o = evt.level;

endmodule

// File: rtl/acb_toggle_gen_chk.sv
module acb_toggle_gen_chk #(
   parameter int unsigned PERIOD_W = 8,
   parameter int unsigned XCNT_W   = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                line_stb_i,
   input logic [PERIOD_W-1:0] period_i,
   input logic [XCNT_W-1:0]   xcount_i,
   input logic                status_clr_i,
   input logic                bias_o,
   input logic                status_o
);
   AST_BIAS_HOLDS_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !line_stb_i |=> $stable(bias_o)); // R9

   AST_ZERO_PERIOD_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (line_stb_i && period_i == '0) |=> (bias_o != $past(bias_o))); // R3

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o && !status_clr_i) |=> status_o); // R5

   AST_FLAG_RISES_WITH_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o) |-> !$stable(bias_o)); // R4

   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (status_clr_i && !line_stb_i) |=> !status_o); // R6

   AST_DISABLED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (xcount_i == '0 && !status_o) |=> !status_o); // R8
endmodule

bind acb_toggle_gen acb_toggle_gen_chk #(.PERIOD_W(PERIOD_W), .XCNT_W(XCNT_W)) u_chk (.*);

// File: tb/tb_acb_toggle_gen.sv
module tb_acb_toggle_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_stb_i = 1'b0;
   logic [7:0] period_i = '0;
   logic [3:0] xcount_i = '0;
   logic       status_clr_i = 1'b0;
   logic       bias_o, status_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state
   int  m_lc = 0, m_tc = 0;
   bit  m_bias = 0, m_flag = 0;

   always #2.5 clk = ~clk;

   acb_toggle_gen dut (.*);

   function automatic void model_step(bit stb, int per, int xc, bit clr);
      int  lim = (per == 0) ? 1 : per;
      bit  tog = stb && (m_lc + 1 >= lim);
      bit  set = tog && xc != 0 && !m_flag && (m_tc + 1 >= xc);
      if (stb) begin
         m_lc = tog ? 0 : m_lc + 1;
         if (tog) m_bias = ~m_bias;
      end
      if (xc == 0) m_tc = 0;
      else if (tog && !m_flag) m_tc = set ? 0 : m_tc + 1;
      if (set) m_flag = 1;
      else if (clr) m_flag = 0;
   endfunction

   task automatic chk(string tag, string what, bit act, bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // one cycle: drive at negedge, model at edge, compare at next negedge
   task automatic cyc(string tag, bit stb, bit clr);
      line_stb_i = stb;
      status_clr_i = clr;
      @(posedge clk);
      model_step(stb, int'(period_i), int'(xcount_i), clr);
      @(negedge clk);
      line_stb_i = 0;
      status_clr_i = 0;
      chk(tag, "bias_o", bias_o, m_bias);
      chk(tag, "status_o", status_o, m_flag);
   endtask

   task automatic strobes(string tag, int n);
      for (int i = 0; i < n; i++) begin
         cyc(tag, 1'b1, 1'b0);
         cyc(tag, 1'b0, 1'b0);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
   end

   initial begin
      bit b0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R1", "bias_o", bias_o, 1'b0);
      chk("R1", "status_o", status_o, 1'b0);
      rst_n = 1;
      @(negedge clk);
      chk("R1", "bias_o", bias_o, 1'b0);

      // R2 and R8: period 3, status disabled
      period_i = 8'd3; xcount_i = 4'd0;
      strobes("R2", 9);
      strobes("R8", 6);

      // R3: period zero flips each strobe
      period_i = 8'd0;
      for (int i = 0; i < 5; i++) begin
         b0 = bias_o;
         cyc("R3", 1'b1, 1'b0);
         chk("R3", "bias flipped", bias_o, ~b0);
      end

      // R4/R5/R6: count 2, period 1
      period_i = 8'd1; xcount_i = 4'd2;
      strobes("R4", 2);
      chk("R4", "flag after 2 flips", status_o, 1'b1);
      strobes("R5", 3);
      chk("R5", "flag held", status_o, 1'b1);
      cyc("R6", 1'b0, 1'b1);
      chk("R6", "flag cleared", status_o, 1'b0);
      strobes("R6", 1);
      chk("R6", "flag low after 1 flip", status_o, 1'b0);
      strobes("R6", 1);
      chk("R6", "flag after 2 fresh flips", status_o, 1'b1);

      // R7: clear coinciding with completing flip
      cyc("R7", 1'b0, 1'b1);
      xcount_i = 4'd1;
      cyc("R7", 1'b1, 1'b1);
      chk("R7", "set wins", status_o, 1'b1);

      // R9: clear and count changes without strobe
      for (int i = 0; i < 6; i++) begin
         b0 = bias_o;
         xcount_i = 4'($urandom_range(0, 15));
         period_i = 8'($urandom_range(0, 255));
         cyc("R9", 1'b0, 1'b1);
         chk("R9", "bias held", bias_o, b0);
      end

      // long period 255
      period_i = 8'd255; xcount_i = 4'd0;
      for (int i = 0; i < 520; i++) cyc("R2", 1'b1, 1'b0);

      // random mix
      for (int i = 0; i < 6000; i++) begin
         bit stb, clr;
         if (i % 400 == 0) begin
            period_i = 8'($urandom_range(0, 6));
            xcount_i = 4'($urandom_range(0, 5));
         end
         stb = ($urandom_range(0, 2) == 0) && !line_stb_i;
         clr = ($urandom_range(0, 15) == 0);
         cyc("R4 random", stb, clr);
      end
      done = 1;
   end

   initial begin
      wait (done);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule